// File: doc/BRIEF.md
# Two-Region I2C Byte Memory Target

This block is an I2C target that reaches two separate byte stores through one bus address. The lower store is a 32-byte clock/calendar register bank at byte addresses 0x00–0x1F. The upper store is a 64-byte general-purpose SRAM at 0x20–0x5F. A controller sends the control byte and then a byte address. After that it either streams data bytes in or issues a repeated START and streams data bytes out. An internal pointer advances after every byte and stays inside the region that was addressed.

SCL and SDA come in asynchronously and pass through two-flop synchronisers. START and STOP are recognised from SDA edges while SCL is high. The target drives SDA only by pulling it low through an open-drain enable. When the backup-supply input is high the target ignores the bus entirely. Timekeeping and clock stretching are not part of this block.

Top module: `i2c_split_mem_target`

## Requirements
- R1: The target acknowledges only the control byte 0xDE (device address 1101111, R/W=0) or 0xDF (R/W=1). Any other control byte is not acknowledged, and the target then acknowledges nothing more until the next START.
- R2: A byte address from 0x00 to 0x5F is acknowledged and loads the pointer. An address from 0x60 to 0xFF is not acknowledged, and the data bytes that follow are neither acknowledged nor stored.
- R3: Each data byte of a write is acknowledged and stored at the pointer address as soon as it completes. No page limit applies, so one transaction can fill a whole region.
- R4: The pointer advances by one after each written or sent byte. It goes from 0x1F back to 0x00 and from 0x5F back to 0x20, for both reads and writes.
- R5: A read is made by writing the address byte only, then a repeated START with control byte 0xDF. The target sends bytes MSB first and continues while the controller acknowledges. After a controller NACK it releases SDA.
- R6: While on_backup_i is 1, the control byte is not acknowledged and neither region is read or written.
- R7: A START or STOP in the middle of a byte ends the transfer. The partial byte is not stored, and the next START begins a fresh control byte.
- R8: sda_oe_o is 0 during and after reset. A value of 1 pulls SDA low. sda_oe_o changes only while the synchronised SCL is low.
- R9: A write to one region leaves every byte of the other region unchanged. Rejected transactions leave both regions unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | I2C clock line, asynchronous |
| sda_i | input | 1 | Resolved I2C data line, asynchronous |
| sda_oe_o | output | 1 | Open-drain enable; 1 pulls SDA low |
| on_backup_i | input | 1 | High while the device runs from backup supply |

## Verification
The bench writes both regions in full and reads each one back one byte past its end. This catches a pointer that wraps across the whole map instead of within the region: such a design would return the first SRAM byte after 0x1F, or an out-of-range byte after 0x5F. Addresses just above 0x5F and control bytes one bit away from 0xDE are sent. A decoder that is off by one would acknowledge them, and it would then corrupt bytes that the final full readback compares. Transfers are also cut short with a STOP or a repeated START partway through a byte, and a transaction is sent under backup mode. A design that stores partial bytes, or that answers under backup mode, would change a byte that the bench later reads.

// File: rtl/i2c_split_mem_pkg.sv
package i2c_split_mem_pkg;
  localparam int unsigned CAL_BYTES_DEF = 32;
  localparam int unsigned RAM_BYTES_DEF = 64;
  localparam logic [6:0]  DEV_ADDR_DEF  = 7'b1101111;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_CTRL,
    PH_ADDR,
    PH_WR,
    PH_RD,
    PH_IGN
  } phase_e;
endpackage

// File: rtl/i2c_split_mem_sync.sv
module i2c_split_mem_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[s] <= '1;
        else         stg_q[s] <= d_i;
      end
    end else begin : g_rest
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[s] <= '1;
        else         stg_q[s] <= stg_q[s-1];
      end
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/i2c_split_mem_cond.sv
module i2c_split_mem_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_s_i,
  input  logic sda_s_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s_i;
      sda_q <= sda_s_i;
    end
  end

  assign scl_rise_o = scl_s_i & ~scl_q;
  assign scl_fall_o = ~scl_s_i & scl_q;
  // SDA edge while SCL held high
  assign start_o    = scl_s_i & scl_q & sda_q & ~sda_s_i;
  assign stop_o     = scl_s_i & scl_q & ~sda_q & sda_s_i;
endmodule

// File: rtl/i2c_split_mem_store.sv
module i2c_split_mem_store #(
  parameter int unsigned CAL_BYTES = 32,
  parameter int unsigned RAM_BYTES = 64
) (
  input  logic       clk_i,
  input  logic       we_i,
  input  logic [7:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o
);
  localparam int unsigned CAL_AW = $clog2(CAL_BYTES);
  localparam int unsigned RAM_AW = $clog2(RAM_BYTES);
  localparam logic [7:0]  RAM_LO = 8'(CAL_BYTES);

  logic [7:0] cal_mem [CAL_BYTES];
  logic [7:0] ram_mem [RAM_BYTES];
  logic       in_cal;
  logic [7:0] ram_off;

  assign in_cal  = addr_i < RAM_LO;
  assign ram_off = addr_i - RAM_LO;

  // contents are not reset
  always_ff @(posedge clk_i) begin
    if (we_i && in_cal)  cal_mem[addr_i[CAL_AW-1:0]] <= wdata_i;
    if (we_i && !in_cal) ram_mem[ram_off[RAM_AW-1:0]] <= wdata_i;
  end

  assign rdata_o = in_cal ? cal_mem[addr_i[CAL_AW-1:0]] : ram_mem[ram_off[RAM_AW-1:0]];
endmodule

// File: rtl/i2c_split_mem_target.sv
module i2c_split_mem_target
  import i2c_split_mem_pkg::*;
#(
  parameter int unsigned CAL_BYTES = CAL_BYTES_DEF,
  parameter int unsigned RAM_BYTES = RAM_BYTES_DEF,
  parameter logic [6:0]  DEV_ADDR  = DEV_ADDR_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe_o,
  input  logic on_backup_i
);
  localparam logic [7:0] RAM_LO   = 8'(CAL_BYTES);
  localparam logic [7:0] CAL_LAST = 8'(CAL_BYTES - 1);
  localparam logic [7:0] RAM_LAST = 8'(CAL_BYTES + RAM_BYTES - 1);

  logic       scl_s, sda_s;
  logic       scl_rise, scl_fall, start_det, stop_det;
  phase_e     phase_q;
  logic [3:0] bit_cnt_q;
  logic [7:0] rx_q, tx_q, ptr_q;
  logic       oe_q;
  logic [7:0] mem_rdata;
  logic       byte_end, ack_end, ctrl_done, addr_done;
  logic       ctrl_ok, addr_ok, mem_we, load_tx, inc_ptr;

  i2c_split_mem_sync #(.WIDTH(2), .STAGES(2)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({scl_i, sda_i}),
    .q_o    ({scl_s, sda_s})
  );

  i2c_split_mem_cond u_cond (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_s_i    (scl_s),
    .sda_s_i    (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_det),
    .stop_o     (stop_det)
  );

  i2c_split_mem_store #(.CAL_BYTES(CAL_BYTES), .RAM_BYTES(RAM_BYTES)) u_store (
    .clk_i   (clk_i),
    .we_i    (mem_we),
    .addr_i  (ptr_q),
    .wdata_i (rx_q),
    .rdata_o (mem_rdata)
  );

  function automatic logic [7:0] ptr_next(input logic [7:0] p);
    if (p == CAL_LAST) return 8'h00;
    if (p == RAM_LAST) return RAM_LO;
    return p + 8'd1;
  endfunction

  logic active;
  assign active    = (phase_q != PH_IDLE) && (phase_q != PH_IGN) && !start_det && !stop_det;
  assign byte_end  = active && scl_fall && (bit_cnt_q == 4'd8);
  assign ack_end   = active && scl_fall && (bit_cnt_q == 4'd9);
  assign ctrl_done = byte_end && (phase_q == PH_CTRL);
  assign addr_done = byte_end && (phase_q == PH_ADDR);
  assign ctrl_ok   = (rx_q[7:1] == DEV_ADDR) && !on_backup_i;
  assign addr_ok   = rx_q <= RAM_LAST;
  assign mem_we    = byte_end && (phase_q == PH_WR);
  assign load_tx   = ack_end && (phase_q == PH_RD);
  assign inc_ptr   = mem_we || load_tx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q   <= PH_IDLE;
      bit_cnt_q <= '0;
      rx_q      <= '0;
      tx_q      <= '0;
      ptr_q     <= '0;
      oe_q      <= 1'b0;
    end else if (start_det) begin
      phase_q   <= PH_CTRL;
      bit_cnt_q <= '0;
      oe_q      <= 1'b0;
    end else if (stop_det) begin
      phase_q   <= PH_IDLE;
      bit_cnt_q <= '0;
      oe_q      <= 1'b0;
    end else if (active) begin
      if (scl_rise) begin
        if (bit_cnt_q < 4'd8) begin
          rx_q      <= {rx_q[6:0], sda_s};
          bit_cnt_q <= bit_cnt_q + 4'd1;
        end else if (bit_cnt_q == 4'd8) begin
          bit_cnt_q <= 4'd9;
          // controller NACK ends a read
          if (phase_q == PH_RD && sda_s) phase_q <= PH_IGN;
        end
      end
      if (scl_fall) begin
        if (bit_cnt_q == 4'd8) begin
          unique case (phase_q)
            PH_CTRL: begin
              if (ctrl_ok) begin
                oe_q    <= 1'b1;
                phase_q <= rx_q[0] ? PH_RD : PH_ADDR;
              end else begin
                phase_q <= PH_IGN;
              end
            end
            PH_ADDR: begin
              if (addr_ok) begin
                oe_q    <= 1'b1;
                ptr_q   <= rx_q;
                phase_q <= PH_WR;
              end else begin
                phase_q <= PH_IGN;
              end
            end
            PH_WR: begin
              oe_q  <= 1'b1;
              ptr_q <= ptr_next(ptr_q);
            end
            default: oe_q <= 1'b0;
          endcase
        end else if (bit_cnt_q == 4'd9) begin
          bit_cnt_q <= '0;
          if (phase_q == PH_RD) begin
            oe_q  <= ~mem_rdata[7];
            tx_q  <= {mem_rdata[6:0], 1'b0};
            ptr_q <= ptr_next(ptr_q);
          end else begin
            oe_q <= 1'b0;
          end
        end else if (bit_cnt_q != 4'd0 && phase_q == PH_RD) begin
          oe_q <= ~tx_q[7];
          tx_q <= {tx_q[6:0], 1'b0};
        end
      end
    end
  end

  assign sda_oe_o = oe_q;
endmodule

// File: rtl/i2c_split_mem_chk.sv
module i2c_split_mem_chk
  import i2c_split_mem_pkg::*;
#(
  parameter int unsigned CAL_BYTES = CAL_BYTES_DEF,
  parameter int unsigned RAM_BYTES = RAM_BYTES_DEF
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       scl_s,
  input logic       sda_oe_o,
  input logic       on_backup_i,
  input logic       start_det,
  input logic       ctrl_done,
  input logic       addr_done,
  input logic       inc_ptr,
  input logic [7:0] rx_q,
  input logic [7:0] ptr_q,
  input logic [3:0] bit_cnt_q,
  input phase_e     phase_q
);
  localparam logic [7:0] RAM_LO   = 8'(CAL_BYTES);
  localparam logic [7:0] CAL_LAST = 8'(CAL_BYTES - 1);
  localparam logic [7:0] RAM_LAST = 8'(CAL_BYTES + RAM_BYTES - 1);

  a_r8_oe_moves_scl_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> !scl_s);

  a_r6_backup_no_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_done && on_backup_i) |=> (!sda_oe_o && phase_q == PH_IGN));

  a_r2_range_nack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_done && rx_q > RAM_LAST) |=> (!sda_oe_o && phase_q == PH_IGN));

  a_r2_ptr_in_map: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_q <= RAM_LAST);

  a_r4_wrap_cal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_ptr && ptr_q == CAL_LAST) |=> ptr_q == 8'h00);

  a_r4_wrap_ram: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_ptr && ptr_q == RAM_LAST) |=> ptr_q == RAM_LO);

  a_r7_start_restarts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_det |=> (bit_cnt_q == 4'd0 && !sda_oe_o && phase_q == PH_CTRL));
endmodule

bind i2c_split_mem_target i2c_split_mem_chk #(
  .CAL_BYTES(CAL_BYTES),
  .RAM_BYTES(RAM_BYTES)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .scl_s       (scl_s),
  .sda_oe_o    (sda_oe_o),
  .on_backup_i (on_backup_i),
  .start_det   (start_det),
  .ctrl_done   (ctrl_done),
  .addr_done   (addr_done),
  .inc_ptr     (inc_ptr),
  .rx_q        (rx_q),
  .ptr_q       (ptr_q),
  .bit_cnt_q   (bit_cnt_q),
  .phase_q     (phase_q)
);

// File: tb/i2c_split_mem_target_bench.sv
module i2c_split_mem_target_bench;
  localparam int T = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic backup = 1'b0;
  logic sda_oe;
  logic sda_bus;
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done = 1'b0;
  logic [7:0] ref_mem [96];

  assign sda_bus = sda_m & ~sda_oe;
  always #2 clk = ~clk;

  i2c_split_mem_target u_i2c_split_mem_target (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .scl_i       (scl_m),
    .sda_i       (sda_bus),
    .sda_oe_o    (sda_oe),
    .on_backup_i (backup)
  );

  function automatic logic [7:0] nxt(input logic [7:0] a);
    if (a == 8'h1F) return 8'h00;
    if (a == 8'h5F) return 8'h20;
    return a + 8'd1;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic hold();
    repeat (T) @(posedge clk);
    #1;
  endtask

  task automatic bus_start();
    sda_m = 1'b1; hold();
    scl_m = 1'b1; hold();
    sda_m = 1'b0; hold();
    scl_m = 1'b0; hold();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; hold();
    scl_m = 1'b1; hold();
    sda_m = 1'b1; hold();
  endtask

  task automatic put_bit(input logic b);
    sda_m = b;    hold();
    scl_m = 1'b1; hold();
    scl_m = 1'b0; hold();
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; hold();
    scl_m = 1'b1; hold();
    b = sda_bus;
    scl_m = 1'b0; hold();
  endtask

  task automatic send_byte(input logic [7:0] d, output logic ack);
    logic x;
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(x);
    ack = ~x;
  endtask

  task automatic recv_byte(output logic [7:0] d, input logic nack);
    logic x;
    for (int i = 7; i >= 0; i--) begin
      get_bit(x);
      d[i] = x;
    end
    put_bit(nack);
  endtask

  task automatic do_write(input logic [7:0] a, input int n, input int seed);
    logic ack;
    logic [7:0] p, d;
    bus_start();
    send_byte(8'hDE, ack); check("R1 ctrl ack", ack, 1);
    send_byte(a, ack);     check("R2 addr ack", ack, 1);
    p = a;
    for (int i = 0; i < n; i++) begin
      d = 8'((seed * 29) ^ (i * 11 + 7));
      send_byte(d, ack); check("R3 data ack", ack, 1);
      ref_mem[p] = d;
      p = nxt(p);
    end
    bus_stop();
  endtask

  task automatic do_read(input logic [7:0] a, input int n, input string req);
    logic ack;
    logic [7:0] p, d;
    bus_start();
    send_byte(8'hDE, ack); check("R5 ctrl ack", ack, 1);
    send_byte(a, ack);     check("R5 addr ack", ack, 1);
    bus_start();
    send_byte(8'hDF, ack); check("R5 read ctrl ack", ack, 1);
    p = a;
    for (int i = 0; i < n; i++) begin
      recv_byte(d, i == n - 1);
      check(req, d, ref_mem[p]);
      p = nxt(p);
    end
    bus_stop();
    check("R5 released after nack", sda_oe, 0);
  endtask

  initial begin
    logic ack;
    logic [7:0] bad_addr [4];
    logic [7:0] bad_ctrl [5];
    bad_addr = '{8'h60, 8'h61, 8'h80, 8'hFF};
    bad_ctrl = '{8'hDC, 8'hDD, 8'h9E, 8'h5E, 8'hFE};

    hold();
    check("R8 reset oe", sda_oe, 0);
    rst_n = 1'b1;
    hold();
    check("R8 idle oe", sda_oe, 0);

    // R3: whole regions in one transaction each
    do_write(8'h00, 32, 1);
    do_write(8'h20, 64, 2);
    // R4: one past each end
    do_read(8'h00, 33, "R4 cal read wrap");
    do_read(8'h20, 65, "R4 ram read wrap");
    // R4: write wrap
    do_write(8'h1D, 5, 3);
    do_write(8'h5E, 4, 4);
    do_read(8'h1C, 6, "R4 cal write wrap");
    do_read(8'h5D, 6, "R4 ram write wrap");
    // R3: single byte
    do_write(8'h41, 1, 5);
    do_read(8'h40, 3, "R3 single byte");
    do_read(8'h5F, 1, "R2 top address");

    // R2: out of range
    foreach (bad_addr[k]) begin
      bus_start();
      send_byte(8'hDE, ack);        check("R2 ctrl ack", ack, 1);
      send_byte(bad_addr[k], ack);  check("R2 addr nack", ack, 0);
      send_byte(8'h5A, ack);        check("R2 data nack", ack, 0);
      bus_stop();
    end

    // R1: wrong device
    foreach (bad_ctrl[k]) begin
      bus_start();
      send_byte(bad_ctrl[k], ack);  check("R1 ctrl nack", ack, 0);
      send_byte(8'h21, ack);        check("R1 no later ack", ack, 0);
      bus_stop();
    end

    // R6: backup mode
    backup = 1'b1;
    bus_start();
    send_byte(8'hDE, ack); check("R6 write ctrl nack", ack, 0);
    send_byte(8'h22, ack); check("R6 addr nack", ack, 0);
    send_byte(8'h00, ack); check("R6 data nack", ack, 0);
    bus_stop();
    bus_start();
    send_byte(8'hDF, ack); check("R6 read ctrl nack", ack, 0);
    bus_stop();
    backup = 1'b0;
    do_read(8'h20, 3, "R6 ram unchanged");

    // R7: STOP partway through a data byte
    bus_start();
    send_byte(8'hDE, ack); check("R7 ctrl ack", ack, 1);
    send_byte(8'h30, ack); check("R7 addr ack", ack, 1);
    put_bit(1'b0); put_bit(1'b1); put_bit(1'b0);
    bus_stop();
    check("R7 oe after stop", sda_oe, 0);
    do_read(8'h30, 1, "R7 partial not stored");

    // R7: repeated START partway through the address byte
    bus_start();
    send_byte(8'hDE, ack); check("R7 ctrl ack", ack, 1);
    put_bit(1'b1); put_bit(1'b0); put_bit(1'b1); put_bit(1'b1);
    do_write(8'h31, 2, 6);
    do_read(8'h30, 4, "R7 after restart");

    // R9: both regions intact after everything
    do_read(8'h00, 32, "R9 cal final");
    do_read(8'h20, 64, "R9 ram final");

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule